// File: doc/BRIEF.md
# Shared Bus Device Port with Grant-Gated Drive

This block attaches one device to a shared bus that is time-sliced by an external dynamic TDMA arbiter. The device writes outgoing flits, each tagged with a destination ID, into a transmit queue. It reads incoming flits from a receive queue. The port raises its own pending bit whenever the transmit queue holds anything. When the arbiter's grant ID names this port, the port places the oldest flit and its destination ID on the bus for one cycle and retires it.

The port does not transmit if the addressed receiver reports its queue as full. In that case the flit stays at the head of the transmit queue until a later grant finds room. Every port watches the resolved bus. A port captures a flit in the same clock edge in which the flit's destination ID equals its own ID.

The bus is modelled as an OR of per-port outputs. Each port forces its data and ID outputs to zero while it is not driving, so the resolved bus carries exactly the granted port's values. A hold variant keeps the queue head on the outputs for use behind external tri-state cells.

Top module: `sbus_node`

## Requirements
- R1: `pending` goes high in the cycle after the transmit queue accepts a flit while empty. It stays high while the queue holds any flit. It goes low in the cycle after the last flit leaves.
- R2: `bus_drive` is high only when `grant_id` equals `MY_ID`, the transmit queue is non-empty, and `peer_full[d]` is low for the head flit's destination `d`. On a bus of ports, at most one port drives in any cycle.
- R3: In a driving cycle, `bus_data_out` and `bus_dest_out` carry the oldest queued flit and its destination, and that flit is removed at the edge. Flits from one source to one destination arrive in write order with none lost or duplicated.
- R4: A port captures the bus flit at the edge of a cycle in which `bus_valid_in` is high and `bus_dest_in` equals `MY_ID`. From the next cycle the flit shows on `rx_data` with `rx_valid` high. A cycle with `rx_ready` and `rx_valid` high removes the head.
- R5: `rx_full` is high exactly when the receive queue holds RX_DEPTH flits. A flit addressed to a full receiver is not sent; it stays at the head of the sender's queue and goes out on a later grant once space exists.
- R6: `tx_ready` is low exactly when the transmit queue holds TX_DEPTH flits. A write while `tx_ready` is low is dropped and leaves the queue contents unchanged.
- R7: With IDLE_MODE set to IDLE_ZERO, `bus_data_out` and `bus_dest_out` are all zeros in every cycle where `bus_drive` is low.
- R8: After reset both queues are empty: `pending`, `rx_valid`, `rx_full` and `bus_drive` are low and `tx_ready` is high.
- R9: A bus flit whose destination ID differs from `MY_ID` leaves this port's receive queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Device writes a flit into the transmit queue |
| tx_data | input | FLIT_W | Outgoing flit payload |
| tx_dest | input | ID_W | Destination port ID of the outgoing flit |
| tx_ready | output | 1 | Transmit queue has room |
| rx_valid | output | 1 | Receive queue holds a flit |
| rx_data | output | FLIT_W | Oldest received flit |
| rx_ready | input | 1 | Device removes the oldest received flit |
| rx_full | output | 1 | Receive queue is full; senders must hold off |
| pending | output | 1 | This port's bit of the shared request vector |
| grant_id | input | ID_W | ID of the port that owns the current slot |
| peer_full | input | NUM_DEV | Full flags of all ports, indexed by port ID |
| bus_drive | output | 1 | This port drives the bus this cycle |
| bus_data_out | output | FLIT_W | Flit offered to the bus |
| bus_dest_out | output | ID_W | Destination ID offered to the bus |
| bus_valid_in | input | 1 | Resolved bus carries a flit |
| bus_data_in | input | FLIT_W | Resolved bus flit |
| bus_dest_in | input | ID_W | Resolved bus destination ID |

## Verification
The bench concentrates on grants that land on a port whose transmit queue is empty or whose head flit targets a full receiver. A port that ignored either condition would put a flit on the bus. That flit would then be duplicated, dropped, or pushed into a full queue. The bench also aims loopback flits at the sender itself and fills the transmit queue past its depth. A port with a broken full check would accept the extra write or let it overwrite a queued flit. A rotating grant that also visits idle ports shows whether a port with a faulty ID compare or idle zeroing corrupts the OR-resolved bus.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

   // How a port's bus outputs behave while it does not own the slot
   typedef enum logic {
      IDLE_ZERO = 1'b0,   // outputs forced to zero, suits an OR-resolved bus
      IDLE_HOLD = 1'b1    // outputs follow the queue head, suits tri-state cells
   } sbus_idle_e;

   function automatic int sbus_id_width(input int n_dev);
      return (n_dev > 1) ? $clog2(n_dev) : 1;
   endfunction

endpackage

// File: rtl/sbus_fifo.sv
module sbus_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             full,
   output logic             empty
);

   localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
   localparam bit               POW2     = (DEPTH == (1 << PTR_W));

   initial begin
      assert (WIDTH >= 1) else $error("sbus_fifo: WIDTH must be at least 1");
      assert (DEPTH >= 1) else $error("sbus_fifo: DEPTH must be at least 1");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt;
   logic             do_push, do_pop;

   assign full    = (cnt == CNT_MAX);
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   // pointer advance: free wrap for power-of-two depths, explicit wrap otherwise
   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (full && $stable(wr_ptr)));

   // R3
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> (empty && $stable(rd_ptr)));

endmodule

// File: rtl/sbus_grant_gate.sv
module sbus_grant_gate #(
   parameter int NUM_DEV = 4,
   parameter int ID_W    = 2,
   parameter int MY_ID   = 0
) (
   input  logic [ID_W-1:0]    grant_id,
   input  logic               tx_empty,
   input  logic [ID_W-1:0]    head_dest,
   input  logic [NUM_DEV-1:0] peer_full,
   output logic               drive
);

   localparam logic [ID_W-1:0] OWN_ID = ID_W'(MY_ID);

   logic dest_full;
   logic granted;

   // destination full lookup; a sparse ID space treats unused IDs as never full
   generate
      if (NUM_DEV == (1 << ID_W)) begin : g_dense
         assign dest_full = peer_full[head_dest];
      end else begin : g_sparse
         logic [(1 << ID_W)-1:0] full_ext;
         assign full_ext  = {{((1 << ID_W) - NUM_DEV){1'b0}}, peer_full};
         assign dest_full = full_ext[head_dest];
      end
   endgenerate

   assign granted = (grant_id == OWN_ID);
   assign drive   = granted && !tx_empty && !dest_full;

endmodule

// File: rtl/sbus_addr_match.sv
module sbus_addr_match #(
   parameter int ID_W  = 2,
   parameter int MY_ID = 0
) (
   input  logic            bus_valid_in,
   input  logic [ID_W-1:0] bus_dest_in,
   output logic            hit
);

   localparam logic [ID_W-1:0] OWN_ID = ID_W'(MY_ID);

   assign hit = bus_valid_in && (bus_dest_in == OWN_ID);

endmodule

// File: rtl/sbus_node.sv
module sbus_node
   import sbus_pkg::*;
#(
   parameter int         NUM_DEV   = 4,
   parameter int         FLIT_W    = 64,
   parameter int         TX_DEPTH  = 4,
   parameter int         RX_DEPTH  = 4,
   parameter int         MY_ID     = 0,
   parameter sbus_idle_e IDLE_MODE = IDLE_ZERO,
   localparam int        ID_W      = sbus_id_width(NUM_DEV)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tx_valid,
   input  logic [FLIT_W-1:0]  tx_data,
   input  logic [ID_W-1:0]    tx_dest,
   output logic               tx_ready,
   output logic               rx_valid,
   output logic [FLIT_W-1:0]  rx_data,
   input  logic               rx_ready,
   output logic               rx_full,
   output logic               pending,
   input  logic [ID_W-1:0]    grant_id,
   input  logic [NUM_DEV-1:0] peer_full,
   output logic               bus_drive,
   output logic [FLIT_W-1:0]  bus_data_out,
   output logic [ID_W-1:0]    bus_dest_out,
   input  logic               bus_valid_in,
   input  logic [FLIT_W-1:0]  bus_data_in,
   input  logic [ID_W-1:0]    bus_dest_in
);

   localparam int TX_W = ID_W + FLIT_W;

   initial begin
      assert (NUM_DEV >= 2) else $error("sbus_node: need at least two ports");
      assert (MY_ID >= 0 && MY_ID < NUM_DEV) else $error("sbus_node: MY_ID out of range");
      assert (FLIT_W >= 1) else $error("sbus_node: FLIT_W must be positive");
      assert (TX_DEPTH >= 1 && RX_DEPTH >= 1) else $error("sbus_node: queue depth must be positive");
   end

   // ---------------- transmit side ----------------
   logic [TX_W-1:0]   tx_head;
   logic [FLIT_W-1:0] head_data;
   logic [ID_W-1:0]   head_dest;
   logic              tx_full, tx_empty, drive;

   sbus_fifo #(.WIDTH(TX_W), .DEPTH(TX_DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (tx_valid),
      .wdata ({tx_dest, tx_data}),
      .pop   (drive),
      .rdata (tx_head),
      .full  (tx_full),
      .empty (tx_empty)
   );

   assign head_dest = tx_head[TX_W-1:FLIT_W];
   assign head_data = tx_head[FLIT_W-1:0];
   assign tx_ready  = !tx_full;
   assign pending   = !tx_empty;

   sbus_grant_gate #(.NUM_DEV(NUM_DEV), .ID_W(ID_W), .MY_ID(MY_ID)) u_gate (
      .grant_id  (grant_id),
      .tx_empty  (tx_empty),
      .head_dest (head_dest),
      .peer_full (peer_full),
      .drive     (drive)
   );

   assign bus_drive = drive;

   generate
      if (IDLE_MODE == IDLE_ZERO) begin : g_idle_zero
         assign bus_data_out = drive ? head_data : '0;
         assign bus_dest_out = drive ? head_dest : '0;
      end else begin : g_idle_hold
         assign bus_data_out = head_data;
         assign bus_dest_out = head_dest;
      end
   endgenerate

   // ---------------- receive side ----------------
   logic rx_hit, rx_empty;

   sbus_addr_match #(.ID_W(ID_W), .MY_ID(MY_ID)) u_match (
      .bus_valid_in (bus_valid_in),
      .bus_dest_in  (bus_dest_in),
      .hit          (rx_hit)
   );

   sbus_fifo #(.WIDTH(FLIT_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_hit),
      .wdata (bus_data_in),
      .pop   (rx_ready),
      .rdata (rx_data),
      .full  (rx_full),
      .empty (rx_empty)
   );

   assign rx_valid = !rx_empty;

   // ---------------- assertions ----------------
   // R1
   pending_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> pending);

   // R2
   drive_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drive |-> ((grant_id == ID_W'(MY_ID)) && pending));

   // R5
   rx_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_hit |-> !rx_full);

   // R4
   capture_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_hit |=> rx_valid);

   // R9
   foreign_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_hit && !rx_ready && !rx_valid) |=> !rx_valid);

endmodule

// File: tb/sbus_node_tb_top.sv
module sbus_node_tb_top;

   localparam int NDEV = 4;
   localparam int W    = 32;
   localparam int TXD  = 4;
   localparam int RXD  = 4;
   localparam int IDW  = 2;

   typedef logic [IDW+W-1:0] ent_t;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic            rst_n;
   logic [NDEV-1:0] tx_valid, tx_ready, rx_ready, rx_valid, pending, drive, rx_full;
   logic [W-1:0]    tx_data [NDEV];
   logic [IDW-1:0]  tx_dest [NDEV];
   logic [W-1:0]    rx_data [NDEV];
   logic [W-1:0]    bdata_o [NDEV];
   logic [IDW-1:0]  bdest_o [NDEV];
   logic [IDW-1:0]  grant;
   logic            bus_valid;
   logic [W-1:0]    bus_data;
   logic [IDW-1:0]  bus_dest;

   // OR-resolved bus
   always_comb begin
      bus_valid = |drive;
      bus_data  = '0;
      bus_dest  = '0;
      for (int i = 0; i < NDEV; i++) begin
         bus_data = bus_data | bdata_o[i];
         bus_dest = bus_dest | bdest_o[i];
      end
   end

   generate
      for (genvar g = 0; g < NDEV; g++) begin : g_node
         sbus_node #(.NUM_DEV(NDEV), .FLIT_W(W), .TX_DEPTH(TXD), .RX_DEPTH(RXD), .MY_ID(g)) dut_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .tx_valid     (tx_valid[g]),
            .tx_data      (tx_data[g]),
            .tx_dest      (tx_dest[g]),
            .tx_ready     (tx_ready[g]),
            .rx_valid     (rx_valid[g]),
            .rx_data      (rx_data[g]),
            .rx_ready     (rx_ready[g]),
            .rx_full      (rx_full[g]),
            .pending      (pending[g]),
            .grant_id     (grant),
            .peer_full    (rx_full),
            .bus_drive    (drive[g]),
            .bus_data_out (bdata_o[g]),
            .bus_dest_out (bdest_o[g]),
            .bus_valid_in (bus_valid),
            .bus_data_in  (bus_data),
            .bus_dest_in  (bus_dest)
         );
      end
   endgenerate

   // reference model state
   ent_t         mtx [NDEV][$];
   logic [W-1:0] mrx [NDEV][$];
   int           seq [NDEV];
   int           checks = 0;
   int           fails  = 0;
   bit           done   = 0;
   int           mode, fixed_g, wr_pct, rd_pct, only_src, dest_force, hold_dev;
   logic [IDW-1:0] last_g;

   task automatic chk(input string tag, input int dev, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s dev%0d actual=%0h expected=%0h", tag, dev, act, exp);
      end
   endtask

   task automatic step();
      logic [IDW-1:0] g;
      bit e_drv [NDEV];
      bit do_rpop [NDEV];
      bit do_push [NDEV];
      @(negedge clk);
      for (int d = 0; d < NDEV; d++) begin
         tx_valid[d] = ((only_src < 0) || (only_src == d)) && (($urandom % 100) < wr_pct);
         tx_dest[d]  = (dest_force >= 0) ? IDW'(dest_force) : IDW'($urandom % NDEV);
         tx_data[d]  = {8'(d), 24'(seq[d])};
         rx_ready[d] = (($urandom % 100) < rd_pct) && (d != hold_dev);
      end
      g = last_g;
      if (mode == 0) begin
         for (int k = 1; k <= NDEV; k++) begin
            if (mtx[(int'(last_g) + k) % NDEV].size() != 0) begin
               g = IDW'((int'(last_g) + k) % NDEV);
               break;
            end
         end
      end else if (mode == 1) begin
         g = last_g + 1'b1;
      end else begin
         g = IDW'(fixed_g);
      end
      grant  = g;
      last_g = g;
      #1;
      for (int d = 0; d < NDEV; d++) begin
         ent_t f;
         f = (mtx[d].size() != 0) ? mtx[d][0] : '0;
         e_drv[d] = (int'(g) == d) && (mtx[d].size() != 0) &&
                    (mrx[int'(f[IDW+W-1:W])].size() < RXD);
      end
      for (int d = 0; d < NDEV; d++) begin
         chk("R1", d, 64'(pending[d]), 64'(mtx[d].size() != 0));
         chk("R6", d, 64'(tx_ready[d]), 64'(mtx[d].size() < TXD));
         chk("R9", d, 64'(rx_valid[d]), 64'(mrx[d].size() != 0));
         if (mrx[d].size() != 0) chk("R4", d, 64'(rx_data[d]), 64'(mrx[d][0]));
         chk("R5", d, 64'(rx_full[d]), 64'(mrx[d].size() == RXD));
         chk("R2", d, 64'(drive[d]), 64'(e_drv[d]));
         if (e_drv[d]) begin
            chk("R3", d, 64'(bdata_o[d]), 64'(mtx[d][0][W-1:0]));
            chk("R3", d, 64'(bdest_o[d]), 64'(mtx[d][0][IDW+W-1:W]));
         end else begin
            chk("R7", d, 64'({bdest_o[d], bdata_o[d]}), 64'd0);
         end
      end
      chk("R2", -1, 64'($countones(drive) <= 1), 64'd1);
      // decisions on the pre-edge state
      for (int d = 0; d < NDEV; d++) begin
         do_rpop[d] = rx_ready[d] && (mrx[d].size() != 0);
         do_push[d] = tx_valid[d] && (mtx[d].size() < TXD);
      end
      for (int d = 0; d < NDEV; d++) if (do_rpop[d]) void'(mrx[d].pop_front());
      for (int d = 0; d < NDEV; d++) begin
         if (e_drv[d]) begin
            ent_t f;
            f = mtx[d].pop_front();
            mrx[int'(f[IDW+W-1:W])].push_back(f[W-1:0]);
         end
      end
      for (int d = 0; d < NDEV; d++) begin
         if (do_push[d]) begin
            mtx[d].push_back({tx_dest[d], tx_data[d]});
            seq[d]++;
         end
      end
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      rst_n = 1'b0;
      tx_valid = '0;
      rx_ready = '0;
      grant = '0;
      last_g = '0;
      for (int d = 0; d < NDEV; d++) begin
         tx_data[d] = '0;
         tx_dest[d] = '0;
         seq[d] = 0;
      end
      mode = 2; fixed_g = 3; wr_pct = 0; rd_pct = 0;
      only_src = -1; dest_force = -1; hold_dev = -1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R8 reset state
      chk("R8", -1, 64'(pending), 64'd0);
      chk("R8", -1, 64'(rx_valid), 64'd0);
      chk("R8", -1, 64'(rx_full), 64'd0);
      chk("R8", -1, 64'(drive), 64'd0);
      chk("R8", -1, 64'(tx_ready), 64'hF);

      // fill port 0 past its depth while the slot sits on idle port 3 (R6, R2)
      only_src = 0; wr_pct = 100; rd_pct = 100;
      run(10);
      // skip-idle grant sequence with random traffic, including loopback
      only_src = -1; mode = 0; wr_pct = 40; rd_pct = 70;
      run(1500);
      // plain rotation that also lands on idle ports
      mode = 1; wr_pct = 50; rd_pct = 50;
      run(1500);
      // everyone targets port 2 while it stops reading (R5 stall)
      mode = 0; hold_dev = 2; dest_force = 2; wr_pct = 60; rd_pct = 80;
      run(300);
      // drain
      hold_dev = -1; dest_force = -1; wr_pct = 0; rd_pct = 100;
      run(200);
      begin
         int left;
         left = 0;
         for (int d = 0; d < NDEV; d++) left += mtx[d].size() + mrx[d].size();
         chk("R3", -1, 64'(left), 64'd0);
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R3 watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule